// File: doc/BRIEF.md
# Scalar memory issue/return tracker

This block sits between the stage that issues scalar memory operations and the port to memory. Each operation carries a two-bit class code (load, store or atomic) and the ID of the wavefront that issued it. Accepted operations wait in an in-order issue queue. The head of that queue is sent to memory only while its class has room in its in-flight budget. Atomics draw from the read-class budget, the same one loads use.

Completed responses come back through a second port. Each carries its own latency wait. Read-class responses (loads and atomics) go into one return queue and stores into another. At most one response retires per cycle. A retirement needs the write-back bus to be ready and, for read-class responses, the scalar register file to be able to accept data. A busy timer then holds the write-back path for a programmable number of cycles.

The timer is driven by a two-state machine:
- RT_OPEN: retirement is allowed.
- RT_HOLD: the timer is non-zero and no retirement may occur.
- RT_OPEN goes to RT_HOLD on a retirement when the programmed length is non-zero.
- RT_HOLD goes back to RT_OPEN when the timer is at its last count (value 1).

Per-wavefront counters track outstanding totals, read-class work and write-class work.

Top module: `smem_track`

## Requirements
- R1: After reset: `iss_ready`=1, `mem_valid`=0, `ret_valid`=0, `busy`=0, both in-flight counts are 0, and every per-wavefront counter is 0.
- R2: A push is taken when `iss_valid` and `iss_ready` are both high. `iss_ready` is low while the issue queue holds IQ_DEPTH entries. A push offered while `iss_ready` is low changes no counter.
- R3: The issue-queue head is offered on `mem_valid`, `mem_kind` and `mem_wf` in the cycle after it is pushed, if its budget allows. Each sent operation increments the in-flight count of its class. Kind code 0 is a load, 1 a store, and 2 or 3 an atomic. Atomics count in `ld_inflight`.
- R4: A read-class head is held while `ld_inflight`, minus a read-class retirement in the same cycle, equals INFL_MAX. A store head is held in the same way against `st_inflight`. A held head blocks every entry behind it.
- R5: A response taken with `rsp_lat`=L in cycle k becomes eligible to retire in cycle k+1+L. Read-class responses go to the read return queue and stores to the store return queue.
- R6: The read return queue head is always the retirement candidate when that queue is non-empty. A store is considered only when the read return queue is empty, even if the read head is blocked.
- R7: The candidate retires only when its wait has expired, `bus_rdy`=1, and the busy timer is idle. A read-class candidate additionally needs `srf_rdy`=1. Stores ignore `srf_rdy`.
- R8: A retirement is shown on `ret_valid`, `ret_kind` and `ret_wf` in that same cycle and decrements the in-flight count of its class. At most one retirement happens per cycle.
- R9: A taken push increments its wavefront's total counter. It also increments the read counter for kinds 0, 2 and 3 and the write counter for kinds 1, 2 and 3. A retirement decrements the same counters, so an atomic releases both the read and write counts. A push and a retirement on the same wavefront in one cycle net to no change.
- R10: A retirement loads the busy timer with `cfg_busy`. `busy` is high, and no retirement happens, for the next `cfg_busy` cycles. With `cfg_busy`=0, retirements may occur in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue stage offers an operation |
| iss_kind | input | 2 | Class code of offered operation |
| iss_wf | input | WF_W | Wavefront ID of offered operation |
| iss_ready | output | 1 | Issue queue can take a push |
| mem_valid | output | 1 | Operation sent to memory this cycle |
| mem_kind | output | 2 | Class code of sent operation |
| mem_wf | output | WF_W | Wavefront ID of sent operation |
| rsp_valid | input | 1 | Memory returns a completed operation |
| rsp_kind | input | 2 | Class code of the response |
| rsp_wf | input | WF_W | Wavefront ID of the response |
| rsp_lat | input | LAT_W | Cycles the response must wait before retiring |
| bus_rdy | input | 1 | Write-back bus to register file is ready |
| srf_rdy | input | 1 | Scalar register file can take destination writes |
| cfg_busy | input | BUSY_W | Busy-timer length loaded on each retirement |
| ret_valid | output | 1 | A response retires this cycle |
| ret_kind | output | 2 | Class code of retiring response |
| ret_wf | output | WF_W | Wavefront ID of retiring response |
| busy | output | 1 | Busy timer running (RT_HOLD) |
| ld_inflight | output | clog2(INFL_MAX+1) | Read-class operations in flight |
| st_inflight | output | clog2(INFL_MAX+1) | Stores in flight |
| wf_total | output | NUM_WF*CNT_W | Per-wavefront outstanding totals, wavefront w at bits w*CNT_W |
| wf_rd | output | NUM_WF*CNT_W | Per-wavefront read-class outstanding counts |
| wf_wr | output | NUM_WF*CNT_W | Per-wavefront write-class outstanding counts |

## Verification
A retirement and an issue decision can fall in the same cycle and interact. The bench fills the read budget so that a load head is held, then lets one load retire. It expects `ret_valid` and `mem_valid` together in that cycle, with `ld_inflight` still at the limit afterwards. A retirement and a push can also land on the same wavefront in one cycle. The bench arranges this and then requires that wavefront's total and read counters to be unchanged.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [1:0] {
        K_LOAD    = 2'd0,
        K_STORE   = 2'd1,
        K_AMO     = 2'd2,
        K_AMO_ALT = 2'd3
    } op_kind_e;

    typedef enum logic [0:0] {
        RT_OPEN = 1'b0,
        RT_HOLD = 1'b1
    } rt_state_e;

    // read-class: loads and atomics share the load budget and return queue
    function automatic logic is_rd_class(input logic [1:0] k);
        return k != K_STORE;
    endfunction

    // write-class: stores and atomics hold a write count
    function automatic logic is_wr_class(input logic [1:0] k);
        return k != K_LOAD;
    endfunction

endpackage

// File: rtl/smem_fifo.sv
module smem_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store_m [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store_m[rp];

    always_ff @(posedge clk) begin
        if (do_push) store_m[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/smem_ret_queue.sv
module smem_ret_queue #(
    parameter int DEPTH = 2,
    parameter int LAT_W = 4,
    parameter int WF_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [1:0]       push_kind,
    input  logic [WF_W-1:0]  push_wf,
    input  logic [LAT_W-1:0] push_lat,
    input  logic             pop,
    output logic             empty,
    output logic [1:0]       head_kind,
    output logic [WF_W-1:0]  head_wf,
    output logic             head_due
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [1:0]       kind_m [DEPTH];
    logic [WF_W-1:0]  wf_m   [DEPTH];
    logic [LAT_W-1:0] dly_m  [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             full, do_push, do_pop;

    assign empty     = (cnt == '0);
    assign full      = (cnt == CW'(DEPTH));
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_kind = kind_m[rp];
    assign head_wf   = wf_m[rp];
    assign head_due  = (dly_m[rp] == '0);

    always_ff @(posedge clk) begin
        if (do_push) begin
            kind_m[wp] <= push_kind;
            wf_m[wp]   <= push_wf;
        end
    end

    // every entry counts its own wait down, so the head is due on arrival at the front
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) dly_m[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (do_push && wp == PW'(i))
                    dly_m[i] <= push_lat;
                else if (dly_m[i] != '0)
                    dly_m[i] <= dly_m[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/smem_wf_counters.sv
module smem_wf_counters #(
    parameter int NUM_WF = 4,
    parameter int CNT_W  = 4,
    parameter int WF_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inc_en,
    input  logic [WF_W-1:0]         inc_wf,
    input  logic                    inc_rd,
    input  logic                    inc_wr,
    input  logic                    dec_en,
    input  logic [WF_W-1:0]         dec_wf,
    input  logic                    dec_rd,
    input  logic                    dec_wr,
    output logic [NUM_WF*CNT_W-1:0] tot_o,
    output logic [NUM_WF*CNT_W-1:0] rd_o,
    output logic [NUM_WF*CNT_W-1:0] wr_o
);
    for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
        logic [CNT_W-1:0] tot_q, rd_q, wr_q;
        logic             hit_i, hit_d;

        assign hit_i = inc_en && (inc_wf == WF_W'(w));
        assign hit_d = dec_en && (dec_wf == WF_W'(w));

        // increment and decrement combine so a same-cycle pair nets out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tot_q <= '0;
                rd_q  <= '0;
                wr_q  <= '0;
            end else begin
                tot_q <= tot_q + CNT_W'(hit_i) - CNT_W'(hit_d);
                rd_q  <= rd_q + CNT_W'(hit_i && inc_rd) - CNT_W'(hit_d && dec_rd);
                wr_q  <= wr_q + CNT_W'(hit_i && inc_wr) - CNT_W'(hit_d && dec_wr);
            end
        end

        assign tot_o[w*CNT_W +: CNT_W] = tot_q;
        assign rd_o[w*CNT_W +: CNT_W]  = rd_q;
        assign wr_o[w*CNT_W +: CNT_W]  = wr_q;
    end
endmodule

// File: rtl/smem_track.sv
module smem_track
    import smem_pkg::*;
#(
    parameter int NUM_WF   = 4,
    parameter int IQ_DEPTH = 4,
    parameter int INFL_MAX = 2,
    parameter int LAT_W    = 4,
    parameter int BUSY_W   = 4,
    parameter int CNT_W    = 4,
    parameter int WF_W     = (NUM_WF > 1) ? $clog2(NUM_WF) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           iss_valid,
    input  logic [1:0]                     iss_kind,
    input  logic [WF_W-1:0]                iss_wf,
    output logic                           iss_ready,
    output logic                           mem_valid,
    output logic [1:0]                     mem_kind,
    output logic [WF_W-1:0]                mem_wf,
    input  logic                           rsp_valid,
    input  logic [1:0]                     rsp_kind,
    input  logic [WF_W-1:0]                rsp_wf,
    input  logic [LAT_W-1:0]               rsp_lat,
    input  logic                           bus_rdy,
    input  logic                           srf_rdy,
    input  logic [BUSY_W-1:0]              cfg_busy,
    output logic                           ret_valid,
    output logic [1:0]                     ret_kind,
    output logic [WF_W-1:0]                ret_wf,
    output logic                           busy,
    output logic [$clog2(INFL_MAX+1)-1:0]  ld_inflight,
    output logic [$clog2(INFL_MAX+1)-1:0]  st_inflight,
    output logic [NUM_WF*CNT_W-1:0]        wf_total,
    output logic [NUM_WF*CNT_W-1:0]        wf_rd,
    output logic [NUM_WF*CNT_W-1:0]        wf_wr
);
    localparam int IW   = $clog2(INFL_MAX + 1);
    localparam int OP_W = 2 + WF_W;

    // ---------------- issue queue ----------------
    logic [OP_W-1:0] iq_head;
    logic            iq_empty, iq_full;
    logic [1:0]      head_kind;
    logic [WF_W-1:0] head_wf;
    logic            send;

    smem_fifo #(.W(OP_W), .DEPTH(IQ_DEPTH)) u_issue_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (iss_valid),
        .din   ({iss_kind, iss_wf}),
        .pop   (send),
        .dout  (iq_head),
        .empty (iq_empty),
        .full  (iq_full)
    );

    assign iss_ready = !iq_full;
    assign head_kind = iq_head[WF_W +: 2];
    assign head_wf   = iq_head[WF_W-1:0];

    // ---------------- return queues ----------------
    logic            rq_empty, sq_empty, rq_due, sq_due;
    logic [1:0]      rq_kind, sq_kind;
    logic [WF_W-1:0] rq_wf, sq_wf;
    logic            rsp_rd;
    logic            ret_rd, ret_st;

    assign rsp_rd = is_rd_class(rsp_kind);

    smem_ret_queue #(.DEPTH(INFL_MAX), .LAT_W(LAT_W), .WF_W(WF_W)) u_rd_ret_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rsp_valid && rsp_rd),
        .push_kind (rsp_kind),
        .push_wf   (rsp_wf),
        .push_lat  (rsp_lat),
        .pop       (ret_rd),
        .empty     (rq_empty),
        .head_kind (rq_kind),
        .head_wf   (rq_wf),
        .head_due  (rq_due)
    );

    smem_ret_queue #(.DEPTH(INFL_MAX), .LAT_W(LAT_W), .WF_W(WF_W)) u_st_ret_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rsp_valid && !rsp_rd),
        .push_kind (rsp_kind),
        .push_wf   (rsp_wf),
        .push_lat  (rsp_lat),
        .pop       (ret_st),
        .empty     (sq_empty),
        .head_kind (sq_kind),
        .head_wf   (sq_wf),
        .head_due  (sq_due)
    );

    // ---------------- retire candidate ----------------
    logic            cand_valid, cand_due, cand_rd;
    logic [1:0]      cand_kind;
    logic [WF_W-1:0] cand_wf;
    logic            retire;

    always_comb begin
        cand_rd = !rq_empty;
        if (cand_rd) begin
            cand_kind = rq_kind;
            cand_wf   = rq_wf;
            cand_due  = rq_due;
        end else begin
            cand_kind = sq_kind;
            cand_wf   = sq_wf;
            cand_due  = sq_due;
        end
        cand_valid = !rq_empty || !sq_empty;
    end

    // ---------------- write-back hold FSM ----------------
    rt_state_e         state_q, state_d;
    logic [BUSY_W-1:0] timer_q;

    assign retire = cand_valid && cand_due && bus_rdy &&
                    (!cand_rd || srf_rdy) && (state_q == RT_OPEN);
    assign ret_rd = retire && cand_rd;
    assign ret_st = retire && !cand_rd;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_OPEN: if (retire && cfg_busy != '0) state_d = RT_HOLD;
            RT_HOLD: if (timer_q == BUSY_W'(1))    state_d = RT_OPEN;
            default: state_d = RT_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RT_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               timer_q <= '0;
        else if (retire)          timer_q <= cfg_busy;
        else if (timer_q != '0)   timer_q <= timer_q - 1'b1;
    end

    assign busy      = (state_q == RT_HOLD);
    assign ret_valid = retire;
    assign ret_kind  = cand_kind;
    assign ret_wf    = cand_wf;

    // ---------------- in-flight budgets ----------------
    logic [IW-1:0] ld_q, st_q, ld_left, st_left;
    logic          head_rd, send_rd, send_st;

    assign head_rd = is_rd_class(head_kind);
    // a same-cycle retirement frees its slot before the head is judged
    assign ld_left = ld_q - IW'(ret_rd);
    assign st_left = st_q - IW'(ret_st);
    assign send    = !iq_empty && (head_rd ? (ld_left < IW'(INFL_MAX))
                                           : (st_left < IW'(INFL_MAX)));
    assign send_rd = send && head_rd;
    assign send_st = send && !head_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q <= '0;
            st_q <= '0;
        end else begin
            ld_q <= ld_left + IW'(send_rd);
            st_q <= st_left + IW'(send_st);
        end
    end

    assign mem_valid   = send;
    assign mem_kind    = head_kind;
    assign mem_wf      = head_wf;
    assign ld_inflight = ld_q;
    assign st_inflight = st_q;

    // ---------------- per-wavefront counters ----------------
    smem_wf_counters #(.NUM_WF(NUM_WF), .CNT_W(CNT_W), .WF_W(WF_W)) u_wf_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_en (iss_valid && !iq_full),
        .inc_wf (iss_wf),
        .inc_rd (is_rd_class(iss_kind)),
        .inc_wr (is_wr_class(iss_kind)),
        .dec_en (retire),
        .dec_wf (cand_wf),
        .dec_rd (is_rd_class(cand_kind)),
        .dec_wr (is_wr_class(cand_kind)),
        .tot_o  (wf_total),
        .rd_o   (wf_rd),
        .wr_o   (wf_wr)
    );
endmodule

// File: rtl/smem_track_chk.sv
module smem_track_chk
    import smem_pkg::*;
#(
    parameter int NUM_WF   = 4,
    parameter int INFL_MAX = 2,
    parameter int BUSY_W   = 4,
    parameter int CNT_W    = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          iss_valid,
    input logic                          iss_ready,
    input logic                          mem_valid,
    input logic [1:0]                    mem_kind,
    input logic                          ret_valid,
    input logic [1:0]                    ret_kind,
    input logic                          bus_rdy,
    input logic                          srf_rdy,
    input logic                          busy,
    input logic [BUSY_W-1:0]             cfg_busy,
    input logic [$clog2(INFL_MAX+1)-1:0] ld_inflight,
    input logic [$clog2(INFL_MAX+1)-1:0] st_inflight,
    input logic [NUM_WF*CNT_W-1:0]       wf_total,
    input logic                          rq_empty
);
    localparam int IW = $clog2(INFL_MAX + 1);

    // R4
    ld_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_inflight <= IW'(INFL_MAX));

    // R4
    st_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_inflight <= IW'(INFL_MAX));

    // R3
    st_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_kind == K_STORE && !(ret_valid && ret_kind == K_STORE))
        |=> st_inflight == $past(st_inflight) + IW'(1));

    // R8
    rd_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && is_rd_class(ret_kind)) |-> ld_inflight != '0);

    // R8
    st_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !is_rd_class(ret_kind)) |-> st_inflight != '0);

    // R6
    store_after_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_kind == K_STORE) |-> rq_empty);

    // R7
    bus_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> bus_rdy);

    // R7
    srf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && is_rd_class(ret_kind)) |-> srf_rdy);

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ret_valid);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && cfg_busy != '0) |=> busy);

    // R2
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready && !ret_valid) |=> $stable(wf_total));
endmodule

bind smem_track smem_track_chk #(
    .NUM_WF   (NUM_WF),
    .INFL_MAX (INFL_MAX),
    .BUSY_W   (BUSY_W),
    .CNT_W    (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_valid   (iss_valid),
    .iss_ready   (iss_ready),
    .mem_valid   (mem_valid),
    .mem_kind    (mem_kind),
    .ret_valid   (ret_valid),
    .ret_kind    (ret_kind),
    .bus_rdy     (bus_rdy),
    .srf_rdy     (srf_rdy),
    .busy        (busy),
    .cfg_busy    (cfg_busy),
    .ld_inflight (ld_inflight),
    .st_inflight (st_inflight),
    .wf_total    (wf_total),
    .rq_empty    (rq_empty)
);

// File: tb/smem_track_tb_top.sv
module smem_track_tb_top;
    localparam int CLK_NS = 10;
    localparam int NWF = 4, IQD = 4, MAXF = 2, LATW = 4, BW = 4, CW = 4, WFW = 2, IW = 2;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              iss_valid = 0, rsp_valid = 0, bus_rdy = 1, srf_rdy = 1;
    logic [1:0]        iss_kind = 0, rsp_kind = 0;
    logic [WFW-1:0]    iss_wf = 0, rsp_wf = 0;
    logic [LATW-1:0]   rsp_lat = 0;
    logic [BW-1:0]     cfg_busy = 0;
    logic              iss_ready, mem_valid, ret_valid, busy;
    logic [1:0]        mem_kind, ret_kind;
    logic [WFW-1:0]    mem_wf, ret_wf;
    logic [IW-1:0]     ld_inflight, st_inflight;
    logic [NWF*CW-1:0] wf_total, wf_rd, wf_wr;

    int n_chk = 0, n_bad = 0;
    logic [WFW+1:0] owed[$];

    always #(CLK_NS/2) clk = ~clk;

    smem_track #(.NUM_WF(NWF), .IQ_DEPTH(IQD), .INFL_MAX(MAXF), .LAT_W(LATW),
                 .BUSY_W(BW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_wf(iss_wf), .iss_ready(iss_ready), .mem_valid(mem_valid),
        .mem_kind(mem_kind), .mem_wf(mem_wf), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_wf(rsp_wf), .rsp_lat(rsp_lat),
        .bus_rdy(bus_rdy), .srf_rdy(srf_rdy), .cfg_busy(cfg_busy),
        .ret_valid(ret_valid), .ret_kind(ret_kind), .ret_wf(ret_wf),
        .busy(busy), .ld_inflight(ld_inflight), .st_inflight(st_inflight),
        .wf_total(wf_total), .wf_rd(wf_rd), .wf_wr(wf_wr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cnt_of(input logic [NWF*CW-1:0] v, input int w);
        return int'(v[w*CW +: CW]);
    endfunction

    task automatic settle();
        #1;
    endtask

    // one clock: settle, note what memory received, advance, drop one-shot inputs
    task automatic go();
        #1;
        if (mem_valid) owed.push_back({mem_kind, mem_wf});
        @(posedge clk);
        #1;
        iss_valid = 0;
        rsp_valid = 0;
    endtask

    task automatic push(input logic [1:0] k, input logic [WFW-1:0] w);
        iss_valid = 1; iss_kind = k; iss_wf = w;
        go();
    endtask

    task automatic respond(input int lat);
        logic [WFW+1:0] e;
        if (owed.size() == 0) begin
            chk("R5 memory model has a sent op to answer", 0, 1);
            go();
        end else begin
            e = owed.pop_front();
            rsp_valid = 1; rsp_kind = e[WFW+1:WFW]; rsp_wf = e[WFW-1:0];
            rsp_lat = LATW'(lat);
            go();
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            settle();
            if (owed.size() > 0) respond(0);
            else if (mem_valid || ld_inflight != 0 || st_inflight != 0) go();
            else break;
        end
        for (int w = 0; w < NWF; w++) begin
            chk("R9 total back to zero", cnt_of(wf_total, w), 0);
            chk("R9 read count back to zero", cnt_of(wf_rd, w), 0);
            chk("R9 write count back to zero", cnt_of(wf_wr, w), 0);
        end
    endtask

    task automatic t_reset();
        settle();
        chk("R1 iss_ready", int'(iss_ready), 1);
        chk("R1 mem_valid", int'(mem_valid), 0);
        chk("R1 ret_valid", int'(ret_valid), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ld_inflight", int'(ld_inflight), 0);
        chk("R1 st_inflight", int'(st_inflight), 0);
        chk("R1 counters", int'(wf_total | wf_rd | wf_wr), 0);
    endtask

    task automatic t_basic_load();
        push(2'd0, 2'd1);
        settle();
        chk("R9 total after load push", cnt_of(wf_total, 1), 1);
        chk("R9 read after load push", cnt_of(wf_rd, 1), 1);
        chk("R9 write after load push", cnt_of(wf_wr, 1), 0);
        chk("R3 mem_valid", int'(mem_valid), 1);
        chk("R3 mem_kind", int'(mem_kind), 0);
        chk("R3 mem_wf", int'(mem_wf), 1);
        go();
        settle();
        chk("R3 ld_inflight after send", int'(ld_inflight), 1);
        chk("R3 queue empty after send", int'(mem_valid), 0);
        respond(2);
        for (int i = 0; i < 2; i++) begin
            settle();
            chk("R5 not yet eligible", int'(ret_valid), 0);
            go();
        end
        settle();
        chk("R5 eligible after wait", int'(ret_valid), 1);
        chk("R8 ret_kind", int'(ret_kind), 0);
        chk("R8 ret_wf", int'(ret_wf), 1);
        go();
        settle();
        chk("R8 ld_inflight after retire", int'(ld_inflight), 0);
        chk("R9 total after retire", cnt_of(wf_total, 1), 0);
    endtask

    task automatic t_atomic();
        push(2'd2, 2'd2);
        settle();
        chk("R9 atomic read count", cnt_of(wf_rd, 2), 1);
        chk("R9 atomic write count", cnt_of(wf_wr, 2), 1);
        chk("R3 atomic mem_kind", int'(mem_kind), 2);
        go();
        settle();
        chk("R3 atomic in ld_inflight", int'(ld_inflight), 1);
        chk("R3 atomic not in st_inflight", int'(st_inflight), 0);
        srf_rdy = 0;
        respond(0);
        settle();
        chk("R7 atomic waits on srf_rdy", int'(ret_valid), 0);
        srf_rdy = 1;
        settle();
        chk("R7 atomic retires", int'(ret_valid), 1);
        chk("R5 atomic via read queue", int'(ret_kind), 2);
        go();
        settle();
        chk("R9 atomic releases read", cnt_of(wf_rd, 2), 0);
        chk("R9 atomic releases write", cnt_of(wf_wr, 2), 0);
        chk("R8 atomic frees ld budget", int'(ld_inflight), 0);
    endtask

    task automatic t_priority();
        bus_rdy = 0;
        push(2'd1, 2'd0);
        push(2'd0, 2'd3);
        go();
        respond(0);
        respond(0);
        settle();
        chk("R7 bus_rdy low blocks", int'(ret_valid), 0);
        bus_rdy = 1; srf_rdy = 0;
        settle();
        chk("R6 blocked read head holds store back", int'(ret_valid), 0);
        srf_rdy = 1;
        settle();
        chk("R6 read first", int'(ret_valid), 1);
        chk("R6 read first kind", int'(ret_kind), 0);
        chk("R6 read first wf", int'(ret_wf), 3);
        go();
        srf_rdy = 0;
        settle();
        chk("R7 store ignores srf_rdy", int'(ret_valid), 1);
        chk("R6 store second kind", int'(ret_kind), 1);
        go();
        settle();
        chk("R8 nothing left to retire", int'(ret_valid), 0);
        srf_rdy = 1;
    endtask

    task automatic t_budget();
        push(2'd0, 2'd0);
        push(2'd0, 2'd0);
        push(2'd0, 2'd0);
        settle();
        chk("R4 ld at limit", int'(ld_inflight), 2);
        chk("R4 third load held", int'(mem_valid), 0);
        push(2'd1, 2'd1);
        settle();
        chk("R4 store behind held head not bypassed", int'(mem_valid), 0);
        push(2'd1, 2'd1);
        push(2'd1, 2'd1);
        settle();
        chk("R2 full queue drops ready", int'(iss_ready), 0);
        chk("R2 wf1 total before refused push", cnt_of(wf_total, 1), 3);
        iss_valid = 1; iss_kind = 2'd1; iss_wf = 2'd1;
        go();
        settle();
        chk("R2 refused push leaves counter", cnt_of(wf_total, 1), 3);
        respond(0);
        settle();
        chk("R4 retire and send same cycle (retire)", int'(ret_valid), 1);
        chk("R4 retire and send same cycle (send)", int'(mem_valid), 1);
        chk("R4 released head is load", int'(mem_kind), 0);
        go();
        settle();
        chk("R4 ld stays at limit", int'(ld_inflight), 2);
        chk("R4 store now sent", int'(mem_valid), 1);
        chk("R4 store kind", int'(mem_kind), 1);
        drain();
    endtask

    task automatic t_busy();
        cfg_busy = 4'd3; bus_rdy = 0;
        push(2'd1, 2'd0);
        push(2'd1, 2'd0);
        go();
        respond(0);
        respond(0);
        bus_rdy = 1;
        settle();
        chk("R10 first retire", int'(ret_valid), 1);
        chk("R10 idle before", int'(busy), 0);
        go();
        for (int i = 0; i < 3; i++) begin
            settle();
            chk("R10 busy during hold", int'(busy), 1);
            chk("R10 no retire during hold", int'(ret_valid), 0);
            go();
        end
        cfg_busy = 4'd0;
        settle();
        chk("R10 hold over", int'(busy), 0);
        chk("R10 retire after hold", int'(ret_valid), 1);
        go();
        bus_rdy = 0;
        push(2'd1, 2'd2);
        push(2'd1, 2'd2);
        go();
        respond(0);
        respond(0);
        bus_rdy = 1;
        settle();
        chk("R10 zero length first", int'(ret_valid), 1);
        go();
        settle();
        chk("R10 zero length back-to-back", int'(ret_valid), 1);
        chk("R10 zero length no busy", int'(busy), 0);
        go();
        settle();
        chk("R8 store queue drained", int'(ret_valid), 0);
    endtask

    task automatic t_same_cycle();
        push(2'd0, 2'd2);
        go();
        respond(0);
        settle();
        chk("R8 retire of wf2 present", int'(ret_valid), 1);
        chk("R8 retire wf", int'(ret_wf), 2);
        chk("R9 wf2 total before", cnt_of(wf_total, 2), 1);
        iss_valid = 1; iss_kind = 2'd0; iss_wf = 2'd2;
        go();
        settle();
        chk("R9 same-cycle net total", cnt_of(wf_total, 2), 1);
        chk("R9 same-cycle net read", cnt_of(wf_rd, 2), 1);
        drain();
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_basic_load();
        t_atomic();
        t_priority();
        t_budget();
        t_busy();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule